// File: doc/BRIEF.md
# SD Command Line Sequencer

This block sends one SD or SDIO command on the single-bit command line and, if asked, collects the card's reply. It sends a 48-bit frame made of the start and direction bits, a 6-bit command index, a 32-bit argument, a CRC7 and a stop bit. It then either finishes at once or listens for a short (48-bit) or long (136-bit) reply. It checks the reply's CRC7 and ends with exactly one of four completion flags: sent, reply-ended, CRC-fail or timeout. The command clock is the block clock, so one bit moves per cycle.

A host loads the index, the argument and the control bits, then pulses `cmd_start` while `cmd_en` is high. A command can be held back until a data transfer ends (`hold_for_data` with `data_busy`). It can also be told to wait for an interrupt indication in place of the reply timeout (`irq_mode` with `irq_seen`). An SDIO suspend command is shown on `suspend_active` while it is in flight. The captured reply fields stay on the outputs until the next command starts.

Top module: `sdcmd_engine`

## Requirements
- R1: A command goes out MSB first as 48 bits, one bit per cycle while `cmd_oe` is high. The order is: 0, 1, index[5:0], argument[31:0], then CRC7 (polynomial x^7+x^3+1, register starting at zero) over those first 40 bits, then a final 1.
- R2: With `reply_kind` 00 or 10 the block waits for no reply. When the last bit is out it sets `flag_sent` and returns to idle (`busy` low).
- R3: With `reply_kind` 01, the first 0 seen on `cmd_in` after the frame starts a 48-bit capture. Index = bits 45:40 and argument = bits 39:8 go to `rsp_index` and `rsp_arg`. If the CRC7 over bits 47:8 equals bits 7:1, `flag_rend` is set.
- R4: With `reply_kind` 11 a 136-bit reply is captured. Bits 127:8 go to `rsp_long`. If the CRC7 over those 120 bits equals bits 7:1, `flag_rend` is set.
- R5: A reply whose CRC7 does not match sets `flag_crcfail` and leaves `flag_rend` low.
- R6: With `irq_mode` low, if no start bit arrives within 64 cycles after the final command bit, `flag_timeout` is set and the block returns to idle.
- R7: With `irq_mode` high there is no timeout. A pulse on `irq_seen` ends the wait and returns the block to idle with no completion flag.
- R8: With `hold_for_data` set, the block stays busy with the line released while `data_busy` is high. It starts the frame only after `data_busy` falls.
- R9: A start is ignored while `cmd_en` is low. Dropping `cmd_en` at any point returns the block to idle, with `cmd_oe` low and `cmd_out` high.
- R10: `suspend_active` is high while a command issued with `suspend` set is in flight, and low otherwise.
- R11: After reset `busy`, `cmd_oe`, all flags and the reply registers are 0 and `cmd_out` is 1. Flags and reply registers hold while idle and are cleared by the next accepted start.
- R12: At most one completion flag is high at any time. A `cmd_start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_en | input | 1 | Sequencer enable |
| cmd_start | input | 1 | One-cycle request to issue a command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| reply_kind | input | 2 | Reply type code |
| irq_mode | input | 1 | Wait for interrupt in place of the timeout |
| hold_for_data | input | 1 | Hold the command until the data path is idle |
| suspend | input | 1 | Command is an SDIO suspend |
| data_busy | input | 1 | Data transfer in progress |
| irq_seen | input | 1 | Interrupt indication from the card |
| cmd_in | input | 1 | Command line as seen from the card |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | A command is in progress |
| suspend_active | output | 1 | A suspend command is in flight |
| flag_sent | output | 1 | Command sent, no reply expected |
| flag_rend | output | 1 | Reply received with good CRC |
| flag_crcfail | output | 1 | Reply received with bad CRC |
| flag_timeout | output | 1 | No reply start within the timeout |
| rsp_index | output | 6 | Index field of a short reply |
| rsp_arg | output | 32 | Argument field of a short reply |
| rsp_long | output | 120 | Payload of a long reply |

## Verification
The properties assume that `cmd_start` reaches the block only as a single-cycle pulse. They also assume `data_busy` and `irq_seen` are plain levels that follow the same clock, and that a card drives `cmd_in` only after the frame has ended. The bench keeps to this. It changes every input only on the falling edge. It raises `cmd_in` only after `cmd_oe` has dropped, leaving a short idle gap first. It holds `irq_seen` for exactly one cycle. Replies are built in the bench from the field layout and the CRC polynomial, and one case flips a CRC bit on purpose.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_SEND,
    ST_WAIT,
    ST_RECV
  } seq_state_e;

  // One serial step of the CRC7 divider, MSB of the message first.
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    crc7_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
  import sdcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      crc_o <= '0;
    end else if (en_i) begin
      crc_o <= crc7_step(crc_o, bit_i);
    end
  end

endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
  import sdcmd_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             abort_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [ARG_W-1:0] arg_i,
  output logic             line_o,
  output logic             oe_o,
  output logic             done_o
);

  localparam int MSG_W   = IDX_W + ARG_W + 2;
  localparam int FRAME_W = MSG_W + CRC_W + 1;
  localparam int CW      = $clog2(FRAME_W);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic [MSG_W-1:0]   msg;
  logic [CRC_W-1:0]   crc;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] sh_q;
  logic [CW-1:0]      cnt_q;

  always_comb begin
    msg = {2'b01, idx_i, arg_i};
    crc = '0;
    for (int i = MSG_W - 1; i >= 0; i--) begin
      crc = crc7_step(crc, msg[i]);
    end
    frame = {msg, crc, 1'b1};
  end

  assign done_o = oe_o && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      oe_o   <= 1'b0;
      line_o <= 1'b1;
    end else if (load_i) begin
      line_o <= frame[FRAME_W-1];
      sh_q   <= {frame[FRAME_W-2:0], 1'b1};
      cnt_q  <= '0;
      oe_o   <= 1'b1;
    end else if (oe_o) begin
      if (done_o) begin
        oe_o   <= 1'b0;
        line_o <= 1'b1;
      end else begin
        line_o <= sh_q[FRAME_W-1];
        sh_q   <= {sh_q[FRAME_W-2:0], 1'b1};
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32,
  parameter int PAY_W = 120
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             begin_i,
  input  logic             run_i,
  input  logic             long_i,
  input  logic             din_i,
  output logic             done_o,
  output logic             crc_ok_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [ARG_W-1:0] arg_o,
  output logic [PAY_W-1:0] pay_o
);

  localparam int SHORT_W = IDX_W + ARG_W + 10;
  localparam int LONG_W  = PAY_W + 16;
  localparam int CW      = $clog2(LONG_W + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_W - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_W - 1);
  localparam logic [CW-1:0] SHORT_CEND = CW'(SHORT_W - 8);
  localparam logic [CW-1:0] LONG_CBEG  = CW'(8);
  localparam logic [CW-1:0] LONG_CEND  = CW'(LONG_W - 8);

  logic [LONG_W-2:0]  sh_q;
  logic [LONG_W-1:0]  nx;
  logic [CW-1:0]      cnt_q;
  logic               crc_en;
  logic [CRC_W-1:0]   crc;

  assign nx     = {sh_q, din_i};
  assign done_o = run_i && (cnt_q == (long_i ? LONG_LAST : SHORT_LAST));
  assign crc_en = run_i && (long_i ? (cnt_q >= LONG_CBEG && cnt_q < LONG_CEND)
                                   : (cnt_q < SHORT_CEND));

  sdcmd_crc7 u_crc (
    .clk   (clk),
    .rst   (rst),
    .clr_i (begin_i),
    .en_i  (crc_en),
    .bit_i (din_i),
    .crc_o (crc)
  );

  assign crc_ok_o = (crc == nx[CRC_W:1]);
  assign idx_o    = nx[SHORT_W-3 -: IDX_W];
  assign arg_o    = nx[ARG_W+7:8];
  assign pay_o    = nx[PAY_W+7:8];

  always_ff @(posedge clk) begin
    if (rst || begin_i) begin
      sh_q  <= '0;
      cnt_q <= begin_i ? CW'(1) : '0;
    end else if (run_i) begin
      sh_q  <= nx[LONG_W-2:0];
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int IDX_W          = 6,
  parameter int ARG_W          = 32,
  parameter int PAY_W          = 120,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_en,
  input  logic             cmd_start,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic [1:0]       reply_kind,
  input  logic             irq_mode,
  input  logic             hold_for_data,
  input  logic             suspend,
  input  logic             data_busy,
  input  logic             irq_seen,
  input  logic             cmd_in,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic             busy,
  output logic             suspend_active,
  output logic             flag_sent,
  output logic             flag_rend,
  output logic             flag_crcfail,
  output logic             flag_timeout,
  output logic [IDX_W-1:0] rsp_index,
  output logic [ARG_W-1:0] rsp_arg,
  output logic [PAY_W-1:0] rsp_long
);

  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT_CYCLES - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [ARG_W-1:0] arg_q;
  logic [1:0]       kind_q;
  logic             irqw_q;
  logic             susp_q;
  logic [TW-1:0]    timer_q;

  logic             tx_load, tx_done;
  logic [IDX_W-1:0] tx_idx;
  logic [ARG_W-1:0] tx_arg;
  logic             rx_begin, rx_run, rx_done, rx_crc_ok;
  logic [IDX_W-1:0] rx_idx;
  logic [ARG_W-1:0] rx_arg;
  logic [PAY_W-1:0] rx_pay;
  logic             in_pend, in_wait;

  assign in_pend = (state_q == ST_PEND);
  assign in_wait = (state_q == ST_WAIT);
  assign busy    = (state_q != ST_IDLE);
  assign suspend_active = susp_q && busy;

  // A direct start frames the live inputs; a held start frames the latched copy.
  assign tx_idx  = (state_q == ST_IDLE) ? cmd_index : idx_q;
  assign tx_arg  = (state_q == ST_IDLE) ? cmd_arg   : arg_q;
  assign tx_load = cmd_en &&
                   (((state_q == ST_IDLE) && cmd_start && !hold_for_data) ||
                    (in_pend && !data_busy));

  sdcmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .load_i  (tx_load),
    .abort_i (!cmd_en),
    .idx_i   (tx_idx),
    .arg_i   (tx_arg),
    .line_o  (cmd_out),
    .oe_o    (cmd_oe),
    .done_o  (tx_done)
  );

  assign rx_begin = cmd_en && in_wait && !cmd_in;
  assign rx_run   = cmd_en && (state_q == ST_RECV);

  sdcmd_rx #(.IDX_W(IDX_W), .ARG_W(ARG_W), .PAY_W(PAY_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .begin_i  (rx_begin),
    .run_i    (rx_run),
    .long_i   (kind_q[1]),
    .din_i    (cmd_in),
    .done_o   (rx_done),
    .crc_ok_o (rx_crc_ok),
    .idx_o    (rx_idx),
    .arg_o    (rx_arg),
    .pay_o    (rx_pay)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      arg_q        <= '0;
      kind_q       <= '0;
      irqw_q       <= 1'b0;
      susp_q       <= 1'b0;
      timer_q      <= '0;
      flag_sent    <= 1'b0;
      flag_rend    <= 1'b0;
      flag_crcfail <= 1'b0;
      flag_timeout <= 1'b0;
      rsp_index    <= '0;
      rsp_arg      <= '0;
      rsp_long     <= '0;
    end else if (!cmd_en) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cmd_start) begin
            idx_q        <= cmd_index;
            arg_q        <= cmd_arg;
            kind_q       <= reply_kind;
            irqw_q       <= irq_mode;
            susp_q       <= suspend;
            flag_sent    <= 1'b0;
            flag_rend    <= 1'b0;
            flag_crcfail <= 1'b0;
            flag_timeout <= 1'b0;
            rsp_index    <= '0;
            rsp_arg      <= '0;
            rsp_long     <= '0;
            state_q      <= hold_for_data ? ST_PEND : ST_SEND;
          end
        end
        ST_PEND: begin
          if (!data_busy) state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (tx_done) begin
            timer_q <= '0;
            if (kind_q[0]) begin
              state_q <= ST_WAIT;
            end else begin
              flag_sent <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end
        end
        ST_WAIT: begin
          if (!cmd_in) begin
            state_q <= ST_RECV;
          end else if (irqw_q) begin
            if (irq_seen) state_q <= ST_IDLE;
          end else if (timer_q == TO_LAST) begin
            flag_timeout <= 1'b1;
            state_q      <= ST_IDLE;
          end else begin
            timer_q <= timer_q + 1'b1;
          end
        end
        ST_RECV: begin
          if (rx_done) begin
            flag_rend    <= rx_crc_ok;
            flag_crcfail <= !rx_crc_ok;
            if (kind_q[1]) begin
              rsp_long  <= rx_pay;
            end else begin
              rsp_index <= rx_idx;
              rsp_arg   <= rx_arg;
            end
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
  input logic clk,
  input logic rst,
  input logic cmd_en,
  input logic cmd_start,
  input logic data_busy,
  input logic cmd_out,
  input logic cmd_oe,
  input logic busy,
  input logic suspend_active,
  input logic flag_sent,
  input logic flag_rend,
  input logic flag_crcfail,
  input logic flag_timeout,
  input logic in_pend,
  input logic in_wait,
  input logic irqw_q
);

  p_oe_in_cmd_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> busy);

  p_enable_drop_r9: assert property (@(posedge clk) disable iff (rst)
    !cmd_en |=> (!busy && !cmd_oe));

  p_line_released_r9: assert property (@(posedge clk) disable iff (rst)
    !cmd_oe |-> cmd_out);

  p_hold_no_drive_r8: assert property (@(posedge clk) disable iff (rst)
    (in_pend && data_busy) |=> !cmd_oe);

  p_no_timeout_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (in_wait && irqw_q) |=> !flag_timeout);

  p_suspend_in_flight_r10: assert property (@(posedge clk) disable iff (rst)
    suspend_active |-> busy);

  p_flags_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cmd_start) |=>
      $stable({flag_sent, flag_rend, flag_crcfail, flag_timeout}));

  p_one_flag_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_sent, flag_rend, flag_crcfail, flag_timeout}));

endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .cmd_en         (cmd_en),
  .cmd_start      (cmd_start),
  .data_busy      (data_busy),
  .cmd_out        (cmd_out),
  .cmd_oe         (cmd_oe),
  .busy           (busy),
  .suspend_active (suspend_active),
  .flag_sent      (flag_sent),
  .flag_rend      (flag_rend),
  .flag_crcfail   (flag_crcfail),
  .flag_timeout   (flag_timeout),
  .in_pend        (in_pend),
  .in_wait        (in_wait),
  .irqw_q         (irqw_q)
);

// File: tb/sdcmd_engine_test.sv
module sdcmd_engine_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_en = 1'b1;
  logic         cmd_start = 1'b0;
  logic [5:0]   cmd_index = '0;
  logic [31:0]  cmd_arg = '0;
  logic [1:0]   reply_kind = '0;
  logic         irq_mode = 1'b0;
  logic         hold_for_data = 1'b0;
  logic         suspend = 1'b0;
  logic         data_busy = 1'b0;
  logic         irq_seen = 1'b0;
  logic         cmd_in = 1'b1;
  logic         cmd_out, cmd_oe, busy, suspend_active;
  logic         flag_sent, flag_rend, flag_crcfail, flag_timeout;
  logic [5:0]   rsp_index;
  logic [31:0]  rsp_arg;
  logic [119:0] rsp_long;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sdcmd_engine uut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [135:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic top = c[6] ^ v[i];
      c = {c[5:0], 1'b0};
      if (top) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] m = {2'b01, idx, arg};
    return {m, crc7({96'd0, m}, 40), 1'b1};
  endfunction

  function automatic logic [3:0] flags();
    return {flag_sent, flag_rend, flag_crcfail, flag_timeout};
  endfunction

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                       input logic iw, input logic pd, input logic sp);
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; reply_kind = kind;
    irq_mode = iw; hold_for_data = pd; suspend = sp;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic grab(output logic [47:0] f);
    for (int k = 0; k < 1000 && !cmd_oe; k++) @(negedge clk);
    for (int i = 47; i >= 0; i--) begin
      f[i] = cmd_out;
      @(negedge clk);
    end
  endtask

  task automatic card_send(input logic [135:0] v, input int n);
    cmd_in = 1'b1;
    @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      cmd_in = v[i];
      @(negedge clk);
    end
    cmd_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset busy", busy, 0);
    chk("R11 reset oe", cmd_oe, 0);
    chk("R11 reset line", cmd_out, 1);
    chk("R11 reset flags", flags(), 0);
    chk("R11 reset arg", rsp_arg, 0);
  endtask

  task automatic t_no_reply();
    logic [47:0] f;
    issue(6'd0, 32'h0000_0000, 2'b00, 0, 0, 0);
    grab(f);
    chk("R1 frame cmd0", f, cmd_frame(6'd0, 32'h0));
    chk("R2 sent 00", flags(), 4'b1000);
    chk("R2 idle 00", busy, 0);
    issue(6'd7, 32'hDEAD_BEEF, 2'b10, 0, 0, 0);
    grab(f);
    chk("R1 frame cmd7", f, cmd_frame(6'd7, 32'hDEAD_BEEF));
    chk("R2 sent 10", flags(), 4'b1000);
    chk("R2 idle 10", busy, 0);
  endtask

  task automatic t_short(input logic bad);
    logic [47:0] f;
    logic [39:0] m = {2'b00, 6'd17, 32'h1234_5678};
    logic [6:0]  c = crc7({96'd0, m}, 40) ^ (bad ? 7'h10 : 7'h00);
    issue(6'd17, 32'hA5A5_0F0F, 2'b01, 0, 0, 0);
    grab(f);
    chk("R1 frame cmd17", f, cmd_frame(6'd17, 32'hA5A5_0F0F));
    chk("R3 waits for reply", busy, 1);
    card_send({88'd0, m, c, 1'b1}, 48);
    chk("R12 one flag short", $countones(flags()), 1);
    if (bad) begin
      chk("R5 crcfail", flag_crcfail, 1);
      chk("R5 no rend", flag_rend, 0);
    end else begin
      chk("R3 rend", flag_rend, 1);
      chk("R3 index", rsp_index, 6'd17);
      chk("R3 arg", rsp_arg, 32'h1234_5678);
      repeat (20) @(negedge clk);
      chk("R11 arg held", rsp_arg, 32'h1234_5678);
      chk("R11 flag held", flag_rend, 1);
      issue(6'd3, 32'h0, 2'b00, 0, 0, 0);
      chk("R11 start clears flag", flag_rend, 0);
      chk("R11 start clears arg", rsp_arg, 0);
      grab(f);
    end
  endtask

  task automatic t_long();
    logic [47:0]  f;
    logic [119:0] pay = {30'h2BADCAFE, 30'h1357_9BDF, 30'h0246_8ACE, 30'h3FFF_0001};
    issue(6'd2, 32'h0, 2'b11, 0, 0, 0);
    grab(f);
    card_send({2'b00, 6'h3F, pay, crc7({16'd0, pay}, 120), 1'b1}, 136);
    chk("R4 rend long", flag_rend, 1);
    chk("R4 payload", rsp_long, pay);
    chk("R12 one flag long", $countones(flags()), 1);
  endtask

  task automatic t_timeout();
    logic [47:0] f;
    issue(6'd9, 32'h55, 2'b01, 0, 0, 0);
    grab(f);
    repeat (60) @(negedge clk);
    chk("R6 still waiting", {busy, flag_timeout}, 2'b10);
    repeat (10) @(negedge clk);
    chk("R6 timeout flag", flag_timeout, 1);
    chk("R6 idle after timeout", busy, 0);
  endtask

  task automatic t_irq();
    logic [47:0] f;
    issue(6'd52, 32'h77, 2'b01, 1, 0, 0);
    grab(f);
    repeat (150) @(negedge clk);
    chk("R7 no timeout", {busy, flag_timeout}, 2'b10);
    cmd_index = 6'd1; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    @(negedge clk);
    chk("R12 start while busy ignored", {busy, cmd_oe}, 2'b10);
    irq_seen = 1'b1;
    @(negedge clk);
    irq_seen = 1'b0;
    @(negedge clk);
    chk("R7 irq ends wait", busy, 0);
    chk("R7 no flag", flags(), 0);
  endtask

  task automatic t_pend();
    logic [47:0] f;
    data_busy = 1'b1;
    issue(6'd24, 32'hCAFE_0001, 2'b00, 0, 1, 0);
    repeat (30) @(negedge clk);
    chk("R8 held", {busy, cmd_oe}, 2'b10);
    data_busy = 1'b0;
    grab(f);
    chk("R8 frame after release", f, cmd_frame(6'd24, 32'hCAFE_0001));
    chk("R8 sent", flag_sent, 1);
  endtask

  task automatic t_enable();
    cmd_en = 1'b0;
    issue(6'd5, 32'h1, 2'b00, 0, 0, 0);
    @(negedge clk);
    chk("R9 start ignored", {busy, cmd_oe}, 2'b00);
    cmd_en = 1'b1;
    issue(6'd5, 32'h1, 2'b00, 0, 0, 0);
    repeat (10) @(negedge clk);
    chk("R9 sending", cmd_oe, 1);
    cmd_en = 1'b0;
    @(negedge clk);
    chk("R9 abort", {busy, cmd_oe, cmd_out}, 3'b001);
    cmd_en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_suspend();
    logic [47:0] f;
    issue(6'd52, 32'h8000_0000, 2'b00, 0, 0, 1);
    chk("R10 suspend shown", suspend_active, 1);
    grab(f);
    chk("R10 suspend cleared", suspend_active, 0);
    issue(6'd52, 32'h0, 2'b00, 0, 0, 0);
    chk("R10 plain command", suspend_active, 0);
    grab(f);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_no_reply();
    t_short(1'b0);
    t_short(1'b1);
    t_long();
    t_timeout();
    t_irq();
    t_pend();
    t_enable();
    t_suspend();
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

endmodule